// File: doc/BRIEF.md
# Comma-Aligned 10-Bit Deserializer

This block takes a recovered serial bit stream, one bit per cycle of the bit clock, and packs it into 10-bit characters. The first bit received in a character lands in bit 0 and the tenth in bit 9. After reset the character boundary free-runs from the first bit clocked in. While the alignment enable is high, a sliding window watches the last seven received bits for the positive comma (0, 0, 1, 1, 1, 1, 1 in arrival order). When it appears, the boundary is moved so that the comma occupies the first seven bits of the next output word.

Each output word comes with two complementary byte clocks at half the character rate. Successive words are launched on the rising edge of the first clock, then the second, in turn. A sync flag goes out together with every word that holds a detected comma. Nominal rates are a 1.0625 Gbit/s bit stream, 106.25 M characters/s and 53.125 MHz byte clocks. Clock recovery and the analog front end sit outside this block.

Top module: `comma_deser`

## Requirements
- R1: In an output word, bit i holds the (i+1)-th received bit of that character: the earliest bit is in bit 0 and the latest in bit 9.
- R2: After reset, until a comma is seen with the enable high, the boundary counts from the first bit after reset and the sync flag stays low.
- R3: When the enable is high and the last seven received bits are 0,0,1,1,1,1,1 (oldest first), the partial character is dropped and the next word is output three bits later with word[6:0] = 7'b1111100.
- R4: The sync flag is high for exactly those words that contain a comma detected with the enable high, and low for all others.
- R5: While the enable is low, commas are ignored: the boundary is kept and the sync flag stays low.
- R6: The two byte clocks are always complementary.
- R7: The word output changes only on a rising edge of a byte clock. Each new word raises exactly one byte clock, the two alternate, and the first word after reset raises the A clock.
- R8: During reset the word is all zeros, sync is low, byte clock A is low and byte clock B is high.
- R9: With no comma realignment, successive words are launched exactly 10 bit cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data bit |
| align_en_i | input | 1 | High lets a comma re-lock the character boundary |
| word_o | output | 10 | Parallel character, bit 0 received first |
| sync_o | output | 1 | High alongside a word holding a detected comma |
| bclk_a_o | output | 1 | Half-rate byte clock, rises with even-numbered words |
| bclk_b_o | output | 1 | Complement of bclk_a_o, rises with odd-numbered words |

## Verification
The bench first moves a comma to offsets other than the current boundary with the enable high. A design that reloads the bit counter off by one would shift the comma out of bits 0..6 and report the wrong word bits. The bench also sends commas with the enable low. A design that does not gate detection with the enable would move the boundary or raise sync, and the later words would differ from the model. Long random runs, with the enable toggling and commas injected, test that the two byte clocks stay complementary and alternate. They also find any word that is launched one cycle early or late after a realignment, or that carries a stale sync flag into the following word.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;
  localparam int CHAR_W   = 10;
  localparam int COMMA_W  = 7;
  // Bit j holds the j-th received bit of the comma: 0,0,1,1,1,1,1.
  localparam logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100;
endpackage

// File: rtl/cd_window.sv
module cd_window #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_i,
  output logic [W-1:0] win_o
);
  logic [W-1:0] hist_q;

  // Newest bit enters at the top; oldest ends in bit 0.
  function automatic logic [W-1:0] push_bit(input logic [W-1:0] h, input logic b);
    return {b, h[W-1:1]};
  endfunction

  assign win_o = push_bit(hist_q, bit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= win_o;
  end
endmodule

// File: rtl/cd_comma_det.sv
module cd_comma_det #(
  parameter int W  = 10,
  parameter int CW = 7,
  parameter logic [CW-1:0] PAT = 7'b1111100
) (
  input  logic [W-1:0] win_i,
  input  logic         en_i,
  output logic         hit_o
);
  function automatic logic tail_match(input logic [W-1:0] w);
    return w[W-1 -: CW] == PAT;
  endfunction

  assign hit_o = en_i && tail_match(win_i);
endmodule

// File: rtl/cd_framer.sv
module cd_framer #(
  parameter int W  = 10,
  parameter int CW = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic emit_o,
  output logic flag_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CW);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c, input logic h);
    if (h)              return RELOAD;
    else if (c == LAST) return '0;
    else                return c + 1'b1;
  endfunction

  assign emit_o = !hit_i && (cnt_q == LAST);
  assign flag_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_step(cnt_q, hit_i);
      if (hit_i)       pend_q <= 1'b1;
      else if (emit_o) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cd_launch.sv
module cd_launch #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         emit_i,
  input  logic [W-1:0] win_i,
  input  logic         flag_i,
  output logic [W-1:0] word_o,
  output logic         sync_o,
  output logic         bclk_a_o,
  output logic         bclk_b_o
);
  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      sync_o <= 1'b0;
      ph_q   <= 1'b0;
    end else if (emit_i) begin
      word_o <= win_i;
      sync_o <= flag_i;
      ph_q   <= ~ph_q;
    end
  end

  assign bclk_a_o = ph_q;
  assign bclk_b_o = ~ph_q;
endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int CHAR_W  = comma_deser_pkg::CHAR_W,
  parameter int COMMA_W = comma_deser_pkg::COMMA_W,
  parameter logic [COMMA_W-1:0] COMMA_PAT = comma_deser_pkg::COMMA_PAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata_i,
  input  logic              align_en_i,
  output logic [CHAR_W-1:0] word_o,
  output logic              sync_o,
  output logic              bclk_a_o,
  output logic              bclk_b_o
);
  logic [CHAR_W-1:0] win_w;
  logic              hit_w;
  logic              emit_w;
  logic              flag_w;

  cd_window #(.W(CHAR_W)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_i(sdata_i), .win_o(win_w)
  );

  cd_comma_det #(.W(CHAR_W), .CW(COMMA_W), .PAT(COMMA_PAT)) u_det (
    .win_i(win_w), .en_i(align_en_i), .hit_o(hit_w)
  );

  cd_framer #(.W(CHAR_W), .CW(COMMA_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_w), .emit_o(emit_w), .flag_o(flag_w)
  );

  cd_launch #(.W(CHAR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .emit_i(emit_w), .win_i(win_w), .flag_i(flag_w),
    .word_o(word_o), .sync_o(sync_o), .bclk_a_o(bclk_a_o), .bclk_b_o(bclk_b_o)
  );
endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk #(
  parameter int CHAR_W  = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CHAR_W-1:0] word_o,
  input logic              sync_o,
  input logic              bclk_a_o,
  input logic              bclk_b_o,
  input logic              hit,
  input logic              emit
);
  // R6
  clk_antiphase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_a_o != bclk_b_o);

  // R7
  word_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(bclk_a_o) && !$rose(bclk_b_o)) |-> $stable(word_o));

  // R7
  one_edge_per_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> ($rose(bclk_a_o) != $rose(bclk_b_o)));

  // R4
  sync_has_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> (word_o[COMMA_W-1:0] == COMMA_PAT));

  // R3
  realign_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !emit);

  // R9
  word_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> !emit);
endmodule

bind comma_deser comma_deser_chk #(
  .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_o(word_o), .sync_o(sync_o),
  .bclk_a_o(bclk_a_o), .bclk_b_o(bclk_b_o), .hit(hit_w), .emit(emit_w)
);

// File: tb/tb_comma_deser.sv
module tb_comma_deser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sdata_i = 1'b0;
  logic       align_en_i = 1'b0;
  logic [9:0] word_o;
  logic       sync_o, bclk_a_o, bclk_b_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string phase = "R8";

  // Behavioural model state
  bit         hist[$];
  int         m_cnt = 0;
  bit         m_pend = 0;
  bit         m_a = 0;
  logic [9:0] m_word = '0;
  bit         m_sync = 0;

  always #2.5 clk = ~clk;

  comma_deser dut (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata_i), .align_en_i(align_en_i),
    .word_o(word_o), .sync_o(sync_o), .bclk_a_o(bclk_a_o), .bclk_b_o(bclk_b_o)
  );

  function automatic bit tail_is_comma();
    int n = hist.size();
    if (n < 7) return 0;
    return hist[n-7] == 0 && hist[n-6] == 0 && hist[n-5] == 1 && hist[n-4] == 1 &&
           hist[n-3] == 1 && hist[n-2] == 1 && hist[n-1] == 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_cnt = 0; m_pend = 0; m_a = 0; m_word = '0; m_sync = 0;
    end else begin
      hist.push_back(sdata_i);
      if (hist.size() > 10) void'(hist.pop_front());
      if (align_en_i && tail_is_comma()) begin
        m_cnt = 7;
        m_pend = 1;
      end else if (m_cnt == 9) begin
        for (int i = 0; i < 10; i++) m_word[i] = hist[hist.size() - 10 + i];
        m_sync = m_pend;
        m_pend = 0;
        m_a = !m_a;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic check_bit(string tag, logic got, logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL [%s] %s got %b exp %b at %0t", phase, tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    compared++;
    if (word_o !== m_word) begin
      mismatched++;
      $display("FAIL [%s] R1 word got %b exp %b at %0t", phase, word_o, m_word, $time);
    end
    check_bit("R4 sync", sync_o, m_sync);
    check_bit("R7 bclk_a", bclk_a_o, m_a);
    check_bit("R6 bclk_b", bclk_b_o, !m_a);
  endtask

  task automatic send(bit b, bit en);
    @(negedge clk);
    compare();
    sdata_i = b;
    align_en_i = en;
  endtask

  task automatic send_comma(bit en);
    send(0, en); send(0, en);
    for (int i = 0; i < 5; i++) send(1, en);
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;

    phase = "R2 R9";
    for (int i = 0; i < 43; i++) send(i % 3 == 0, 0);

    phase = "R5";
    send(1, 0); send(0, 0); send(1, 0);
    send_comma(0);
    for (int i = 0; i < 24; i++) send(i % 2, 0);

    phase = "R3";
    send(1, 1); send(0, 1);
    send_comma(1);
    for (int i = 0; i < 23; i++) send(i % 2, 1);
    send(1, 1); send(1, 1);
    send_comma(1);
    for (int i = 0; i < 21; i++) send(i % 2, 1);

    phase = "R4";
    for (int w = 0; w < 4; w++) begin
      send_comma(1);
      send(0, 1); send(1, 1); send(0, 1);
    end
    for (int i = 0; i < 30; i++) send(i % 2, 1);

    phase = "R1";
    for (int w = 0; w < 10; w++)
      for (int i = 0; i < 10; i++) send(i == w, 0);

    phase = "R3 R5 mix";
    for (int k = 0; k < 300; k++) begin
      bit en = ($urandom % 3) != 0;
      if ($urandom % 9 == 0) send_comma(en);
      else send(1'($urandom % 2), en);
    end
    send(0, 0); send(0, 0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      #100000;
    join_any
    if (!finished) begin
      mismatched++;
      $display("FAIL [watchdog] run did not finish");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule